// File: doc/BRIEF.md
# Dual-Pin Edge Interrupt Controller

This block watches two external input pins and turns a programmed edge on either of them into an interrupt request. Each pin first passes through a two-stage synchronizer. An edge detector then compares each synchronized sample with the one before it. A 2-bit mode field per channel selects which transitions count: rising only, falling only, or any change. The fourth code is reserved and never produces a request.

A qualifying edge always latches the channel's pending flag, whatever the channel enable says. The single vector request to the CPU is raised only when some channel has both its flag and its enable set, the global enable is on, and the system is not asleep. Both channels share one fixed vector address. Software reaches the block through a plain register port: an address, a write strobe with write data, and read data that is combinational on the address. Through this port it programs the edge modes, sets the enables, and clears flags by writing 1s. When the CPU takes the vector it pulses `vec_ack_i`, and the global enable drops so that the handler is not re-entered.

While `sleep_i` is high, any change on either pin raises `wake_o` so that external logic can restart the clock. Only a change that matches the programmed direction latches a flag. The vector stays held off until `sleep_i` falls, and it is presented in that same cycle. All control pins are plain level signals; the block carries no data stream, so no valid/ready handshake is needed.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the edge-mode register (address 0) reads 0x0A, meaning both channels are set to falling edge. The enable register (address 1) and the flag register (address 2) read 0x00, `vec_req_o` is 0 and `vec_addr_o` is 8.
- R2: Mode code 01 (channel 0 in bits [1:0], channel 1 in bits [3:2]) sets the flag on a rising edge only. The flag becomes visible on the third rising clock edge after the pin changes.
- R3: Mode code 10 sets the flag on a falling edge only.
- R4: Mode code 11 sets the flag on both rising and falling edges.
- R5: Mode code 00 never sets the flag, for either edge.
- R6: A qualifying edge sets flag bit n of register 2 even when enable bit n is 0. A flag whose channel enable is 0 never raises `vec_req_o`.
- R7: `vec_req_o` is 1 exactly when some channel has its flag and its enable both 1, the global enable (bit 7 of register 1) is 1, and `sleep_i` is 0.
- R8: Writing 1 to bit n of register 2 clears flag n; writing 0 to a bit leaves it unchanged. If a clear and a qualifying edge on that channel fall in the same cycle, the flag stays set.
- R9: While `sleep_i` is 1, any pin change pulses `wake_o`, but only a change in the programmed direction sets a flag. `vec_req_o` stays 0 during sleep and rises in the same cycle that `sleep_i` falls. `wake_o` is 0 while awake.
- R10: A cycle with `vec_req_o` and `vec_ack_i` both 1 clears the global enable.
- R11: Register bits [7:4] of address 0 and bits [6:2] of address 1 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Raw external interrupt pins, one per channel |
| sleep_i | input | 1 | System is in power-down or low-power mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational on `addr_i` |
| vec_req_o | output | 1 | Interrupt vector request to the CPU |
| vec_ack_i | input | 1 | CPU has taken the vector |
| vec_addr_o | output | 8 | Shared vector address |
| wake_o | output | 1 | Wake-up pulse on any pin change while asleep |

## Verification
The hardest case to reach is a software clear that lands in the same clock cycle as a new qualifying edge on that channel. The stimulus changes the pin on a falling clock edge and lets two rising edges pass through the synchronizer. It then asserts the clear write on the next falling edge, so that the write and the detected edge meet at the third rising edge. The sleep case is reached in a similar way. A mismatched edge and then a matched edge are driven while `sleep_i` is high, and `sleep_i` is dropped only after the flag is seen to be set but held off.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int MODE_W = 2;

  localparam logic [1:0] RA_MODE = 2'd0;
  localparam logic [1:0] RA_EN   = 2'd1;
  localparam logic [1:0] RA_FLAG = 2'd2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect
  import pin_irq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      level_i,
  input  logic [NCH*MODE_W-1:0] mode_i,
  output logic [NCH-1:0]      hit_o,
  output logic [NCH-1:0]      change_o
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic       rise, fall;
    edge_mode_e mode;
    assign rise = level_i[i] & ~prev_q[i];
    assign fall = ~level_i[i] & prev_q[i];
    assign mode = edge_mode_e'(mode_i[i*MODE_W +: MODE_W]);
    assign change_o[i] = rise | fall;
    always_comb begin
      unique case (mode)
        EDGE_RISE: hit_o[i] = rise;
        EDGE_FALL: hit_o[i] = fall;
        EDGE_BOTH: hit_o[i] = rise | fall;
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_ADDR    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_i,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              vec_req_o,
  input  logic              vec_ack_i,
  output logic [DATA_W-1:0] vec_addr_o,
  output logic              wake_o
);
  localparam int CFG_W = NCH * MODE_W;
  localparam int GIE_B = DATA_W - 1;

  function automatic logic [CFG_W-1:0] mode_reset();
    logic [CFG_W-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*MODE_W +: MODE_W] = EDGE_FALL;
    return v;
  endfunction

  logic [NCH-1:0]   level;
  logic [NCH-1:0]   edge_hit;
  logic [NCH-1:0]   edge_chg;
  logic [CFG_W-1:0] mode_q;
  logic [NCH-1:0]   en_q;
  logic             gie_q;
  logic [NCH-1:0]   flag_q;
  logic [NCH-1:0]   clr;
  logic             wr_mode, wr_en, wr_flag;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  pin_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (level)
  );

  pin_edge_detect #(.NCH(NCH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (level),
    .mode_i   (mode_q),
    .hit_o    (edge_hit),
    .change_o (edge_chg)
  );

  assign wr_mode = wr_en_i && (addr_i == ADDR_W'(RA_MODE));
  assign wr_en   = wr_en_i && (addr_i == ADDR_W'(RA_EN));
  assign wr_flag = wr_en_i && (addr_i == ADDR_W'(RA_FLAG));
  assign clr     = wr_flag ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= mode_reset();
    else if (wr_mode) mode_q <= wdata_i[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wdata_i[NCH-1:0];
      if (vec_req_o && vec_ack_i) gie_q <= 1'b0;
      else if (wr_en)             gie_q <= wdata_i[GIE_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | edge_hit;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(RA_MODE): rdata_o[CFG_W-1:0] = mode_q;
      ADDR_W'(RA_EN): begin
        rdata_o[NCH-1:0] = en_q;
        rdata_o[GIE_B]   = gie_q;
      end
      ADDR_W'(RA_FLAG): rdata_o[NCH-1:0] = flag_q;
      default: rdata_o = '0;
    endcase
  end

  assign vec_req_o  = gie_q && !sleep_i && (|(flag_q & en_q));
  assign vec_addr_o = DATA_W'(VEC_ADDR);
  assign wake_o     = sleep_i && (|edge_chg);
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
  parameter int NCH   = 2,
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_i,
  input logic             vec_req_o,
  input logic             vec_ack_i,
  input logic             wake_o,
  input logic             gie_q,
  input logic [NCH-1:0]   en_q,
  input logic [NCH-1:0]   flag_q,
  input logic [NCH-1:0]   edge_hit,
  input logic [NCH-1:0]   clr,
  input logic [CFG_W-1:0] mode_q
);
  assert_sleep_holds_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !vec_req_o);

  assert_vec_needs_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> (|(flag_q & en_q)) && gie_q);

  assert_ack_drops_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && vec_ack_i) |=> !gie_q);

  assert_wake_only_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleep_i);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> flag_q[i]);

    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !edge_hit[i]) |=> !flag_q[i]);

    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && mode_q[2*i +: 2] == 2'b00) |=> !flag_q[i]);
  end
endmodule

bind pin_irq_ctrl pin_irq_chk #(.NCH(NCH), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_i   (sleep_i),
  .vec_req_o (vec_req_o),
  .vec_ack_i (vec_ack_i),
  .wake_o    (wake_o),
  .gie_q     (gie_q),
  .en_q      (en_q),
  .flag_q    (flag_q),
  .edge_hit  (edge_hit),
  .clr       (clr),
  .mode_q    (mode_q)
);

// File: tb/sim_pin_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pin_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin = 2'b00;
  logic       sleep = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       vec_req;
  logic       vec_ack = 1'b0;
  logic [7:0] vec_addr;
  logic       wake;
  logic       last_wake = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  pin_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sleep_i(sleep),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .vec_req_o(vec_req), .vec_ack_i(vec_ack), .vec_addr_o(vec_addr),
    .wake_o(wake)
  );

  initial begin : monitor
    forever begin
      item_t it;
      logic [7:0] act;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {7'd0, vec_req};
        2: act = {7'd0, last_wake};
        default: act = vec_addr;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic push_exp(input string req, input int kind, input logic [7:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #0;
  endtask

  task automatic chk_reg(input logic [1:0] a, input string req, input logic [7:0] exp);
    addr = a;
    #1;
    push_exp(req, 0, exp);
  endtask

  task automatic chk_vec(input string req, input logic exp);
    push_exp(req, 1, {7'd0, exp});
  endtask

  task automatic chk_wake(input string req, input logic exp);
    push_exp(req, 2, {7'd0, exp});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive_pin(input int ch, input logic v);
    @(negedge clk);
    pin[ch] = v;
    @(posedge clk);
    @(posedge clk);
    #1 last_wake = wake;
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : driver
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_reg(2'd0, "R1 mode reset", 8'h0A);
    chk_reg(2'd1, "R1 enable reset", 8'h00);
    chk_reg(2'd2, "R1 flag reset", 8'h00);
    chk_vec("R1 vec reset", 1'b0);
    push_exp("R1 vec address", 3, 8'd8);

    // R3 default falling
    drive_pin(0, 1'b1);
    chk_reg(2'd2, "R3 rise ignored", 8'h00);
    drive_pin(0, 1'b0);
    chk_reg(2'd2, "R3 fall sets", 8'h01);
    wr(2'd2, 8'h00);
    chk_reg(2'd2, "R8 zero write keeps", 8'h01);
    wr(2'd2, 8'h01);
    chk_reg(2'd2, "R8 w1c clears", 8'h00);

    // R2 rising only, R5 reserved on ch1
    wr(2'd0, 8'h01);
    chk_reg(2'd0, "R2 mode write", 8'h01);
    drive_pin(0, 1'b1);
    chk_reg(2'd2, "R2 rise sets", 8'h01);
    wr(2'd2, 8'h01);
    drive_pin(0, 1'b0);
    chk_reg(2'd2, "R2 fall ignored", 8'h00);
    drive_pin(1, 1'b1);
    chk_reg(2'd2, "R5 reserved rise", 8'h00);
    drive_pin(1, 1'b0);
    chk_reg(2'd2, "R5 reserved fall", 8'h00);

    // R4 both edges, R11 unused bits
    wr(2'd0, 8'hFF);
    chk_reg(2'd0, "R11 mode upper bits", 8'h0F);
    drive_pin(1, 1'b1);
    chk_reg(2'd2, "R4 rise sets", 8'h02);
    wr(2'd2, 8'h02);
    drive_pin(1, 1'b0);
    chk_reg(2'd2, "R4 fall sets", 8'h02);
    wr(2'd2, 8'h02);
    chk_reg(2'd2, "R4 cleared", 8'h00);
    wr(2'd1, 8'h7F);
    chk_reg(2'd1, "R11 enable unused bits", 8'h03);

    // R6 / R7 flag and vector gating
    drive_pin(0, 1'b1);
    chk_reg(2'd2, "R6 flag without gie", 8'h01);
    chk_vec("R7 no vec without gie", 1'b0);
    wr(2'd1, 8'h80);
    chk_vec("R6 no vec with channel disabled", 1'b0);
    wr(2'd1, 8'h81);
    #1;
    chk_vec("R7 vec asserted", 1'b1);

    // R10 ack clears global enable
    @(negedge clk) vec_ack = 1'b1;
    @(negedge clk) vec_ack = 1'b0;
    chk_reg(2'd1, "R10 gie cleared", 8'h01);
    chk_vec("R10 vec dropped", 1'b0);
    wr(2'd2, 8'h01);

    // R8 same-cycle clear and edge
    drive_pin(0, 1'b0);
    chk_reg(2'd2, "R8 setup flag", 8'h01);
    @(negedge clk) pin[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h01;
    @(negedge clk) wr_en = 1'b0;
    chk_reg(2'd2, "R8 edge beats clear", 8'h01);
    wr(2'd2, 8'h01);
    chk_reg(2'd2, "R8 later clear", 8'h00);

    // R9 sleep behaviour
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h83);
    @(negedge clk) sleep = 1'b1;
    drive_pin(0, 1'b0);
    chk_wake("R9 wake on mismatched edge", 1'b1);
    chk_reg(2'd2, "R9 mismatched no flag", 8'h00);
    drive_pin(0, 1'b1);
    chk_wake("R9 wake on matched edge", 1'b1);
    chk_reg(2'd2, "R9 matched flag latched", 8'h01);
    chk_vec("R9 vec held in sleep", 1'b0);
    @(negedge clk) sleep = 1'b0;
    #1;
    chk_vec("R9 vec on wake", 1'b1);
    drive_pin(1, 1'b1);
    chk_wake("R9 no wake while awake", 1'b0);

    done = 1'b1;
    report();
  end
endmodule